// File: doc/BRIEF.md
# Pin Event Detector

This block watches a bank of already-filtered digital pin inputs and raises a per-pin status flag when a chosen condition appears on a pin. Each pin carries a 4-bit condition code that picks either an edge (rising, falling or either) or a level (low or high). The code also selects whether the pin is serviced by a processor interrupt or by a DMA engine.

Flags of interrupt-mode pins combine into one interrupt line. Flags of DMA-mode pins combine into one DMA request line. Software clears an interrupt-mode flag by writing a one to it. It can do this through the pin's own register or through a status word that gathers every flag. A completion pulse from the DMA engine wipes the flags of all DMA-mode pins at once.

A level condition that still holds keeps its flag set, because a new detection and a clear in the same cycle resolve in favour of the detection.

Top module: `pin_evt_detector`

## Requirements
- R1: After reset every condition code reads 0, every flag is 0, and both `irq` and `dma_req` are low.
- R2: Code 0x0 and the reserved codes 0x4–0x7 and 0xD–0xF never set a flag, whatever the pin does.
- R3: Codes 0x1 (DMA) and 0x9 (interrupt) set the pin's flag one clock after the pin goes from 0 to 1. A 1-to-0 change does not set it.
- R4: Codes 0x2 (DMA) and 0xA (interrupt) set the flag one clock after a 1-to-0 change, and not after a 0-to-1 change.
- R5: Codes 0x3 (DMA) and 0xB (interrupt) set the flag one clock after a change in either direction.
- R6: Code 0x8 sets the flag on every clock where the pin is 0. Code 0xC does the same where the pin is 1. Clearing such a flag while the level persists leaves it set.
- R7: A flag set under an interrupt code (0x8–0xC) stays set until it is cleared by a write of 1. Time, pin activity and the DMA completion pulse do not clear it.
- R8: A one-cycle pulse on `dma_done` clears the flag of every pin whose code is 0x1–0x3, and no other flag.
- R9: `irq` is high exactly when some pin with an interrupt code has its flag set. `dma_req` is high exactly when some pin with a DMA code has its flag set.
- R10: A detection and a clear of the same flag in the same cycle leave the flag set.
- R11: Address `NUM_PINS` reads the status word, with bit i holding pin i's flag and upper bits 0. Writing it clears the flags at the bit positions written as 1 and leaves the others. Writing all ones clears every flag.
- R12: Address i below `NUM_PINS` reads and writes pin i's register. Bits [3:0] hold the code and bit 24 holds the flag. A write always loads the code, and it clears the flag when bit 24 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Filtered pin levels |
| dma_done | input | 1 | One-cycle pulse on completion of a DMA transfer |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address (pin register or status word) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 1 | Combined DMA request |

## Verification
The bench builds the block with `NUM_PINS` = 8 and `DATA_W` = 32. This gives each of the eight pins its own code in a single run, so all interrupt, DMA, level, edge and reserved codes are exercised side by side. Eight pins also put the status word at address 8 and leave the unused upper status bits visible as zeros. Mixing a DMA pin and an interrupt pin in one event shows that the completion pulse and the two request lines separate the two kinds correctly.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

    localparam int CODE_W   = 4;
    localparam int FLAG_BIT = 24;

    typedef enum logic [CODE_W-1:0] {
        COND_OFF      = 4'h0,
        COND_DMA_RISE = 4'h1,
        COND_DMA_FALL = 4'h2,
        COND_DMA_BOTH = 4'h3,
        COND_IRQ_LOW  = 4'h8,
        COND_IRQ_RISE = 4'h9,
        COND_IRQ_FALL = 4'hA,
        COND_IRQ_BOTH = 4'hB,
        COND_IRQ_HIGH = 4'hC
    } cond_e;

    function automatic logic is_dma(input logic [CODE_W-1:0] code);
        return (code == COND_DMA_RISE) || (code == COND_DMA_FALL) || (code == COND_DMA_BOTH);
    endfunction

    function automatic logic is_irq(input logic [CODE_W-1:0] code);
        return (code >= COND_IRQ_LOW) && (code <= COND_IRQ_HIGH);
    endfunction

    // Does the condition selected by code hold for this sample pair?
    function automatic logic cond_hit(input logic [CODE_W-1:0] code,
                                      input logic cur, input logic prev);
        logic rise, fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (code)
            COND_DMA_RISE, COND_IRQ_RISE: return rise;
            COND_DMA_FALL, COND_IRQ_FALL: return fall;
            COND_DMA_BOTH, COND_IRQ_BOTH: return rise | fall;
            COND_IRQ_LOW:                 return ~cur;
            COND_IRQ_HIGH:                return cur;
            default:                      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pin_evt_cond.sv
module pin_evt_cond
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0]        pin_cur,
    input  logic [NUM_PINS-1:0]        pin_prev,
    input  logic [NUM_PINS*CODE_W-1:0] cfg,
    output logic [NUM_PINS-1:0]        set_vec,
    output logic [NUM_PINS-1:0]        irq_mask,
    output logic [NUM_PINS-1:0]        dma_mask
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign set_vec[i]  = cond_hit(cfg[i*CODE_W +: CODE_W], pin_cur[i], pin_prev[i]);
        assign irq_mask[i] = is_irq(cfg[i*CODE_W +: CODE_W]);
        assign dma_mask[i] = is_dma(cfg[i*CODE_W +: CODE_W]);
    end

endmodule

// File: rtl/pin_evt_decode.sv
module pin_evt_decode
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NUM_PINS-1:0] cfg_we,
    output logic [CODE_W-1:0]   cfg_wval,
    output logic [NUM_PINS-1:0] clr_vec
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);

    logic stat_hit;
    logic unused_wdata;

    assign stat_hit     = wr_en && (addr == STAT_ADDR);
    assign cfg_wval     = wdata[CODE_W-1:0];
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_dec
        logic pin_hit;
        assign pin_hit    = wr_en && (addr == ADDR_W'(i));
        assign cfg_we[i]  = pin_hit;
        assign clr_vec[i] = (pin_hit && wdata[FLAG_BIT]) || (stat_hit && wdata[i]);
    end

endmodule

// File: rtl/pin_evt_state.sv
module pin_evt_state
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PINS-1:0]         pin_in,
    input  logic [NUM_PINS-1:0]         set_vec,
    input  logic [NUM_PINS-1:0]         clr_vec,
    input  logic [NUM_PINS-1:0]         dma_mask,
    input  logic                        dma_done,
    input  logic [NUM_PINS-1:0]         cfg_we,
    input  logic [CODE_W-1:0]           cfg_wval,
    output logic [NUM_PINS*CODE_W-1:0]  cfg_q,
    output logic [NUM_PINS-1:0]         flags_q,
    output logic [NUM_PINS-1:0]         prev_q
);

    typedef struct packed {
        logic [NUM_PINS*CODE_W-1:0] cfg;
        logic [NUM_PINS-1:0]        flags;
        logic [NUM_PINS-1:0]        prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        logic [NUM_PINS-1:0] wipe;
        st_d      = st_q;
        st_d.prev = pin_in;
        wipe      = clr_vec | (dma_done ? dma_mask : '0);
        // a detection in the same cycle overrides any clear
        st_d.flags = (st_q.flags & ~wipe) | set_vec;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (cfg_we[i]) begin
                st_d.cfg[i*CODE_W +: CODE_W] = cfg_wval;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q   = st_q.cfg;
    assign flags_q = st_q.flags;
    assign prev_q  = st_q.prev;

endmodule

// File: rtl/pin_evt_detector.sv
module pin_evt_detector
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_PINS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                dma_done,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                irq,
    output logic                dma_req
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_PINS);

    logic [NUM_PINS*CODE_W-1:0] cfg_q;
    logic [NUM_PINS-1:0]        flags_q, prev_q;
    logic [NUM_PINS-1:0]        set_vec, clr_vec, cfg_we;
    logic [NUM_PINS-1:0]        irq_mask, dma_mask;
    logic [CODE_W-1:0]          cfg_wval;

    pin_evt_cond #(.NUM_PINS(NUM_PINS)) u_cond (
        .pin_cur  (pin_in),
        .pin_prev (prev_q),
        .cfg      (cfg_q),
        .set_vec  (set_vec),
        .irq_mask (irq_mask),
        .dma_mask (dma_mask)
    );

    pin_evt_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cfg_we   (cfg_we),
        .cfg_wval (cfg_wval),
        .clr_vec  (clr_vec)
    );

    pin_evt_state #(.NUM_PINS(NUM_PINS)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .dma_mask (dma_mask),
        .dma_done (dma_done),
        .cfg_we   (cfg_we),
        .cfg_wval (cfg_wval),
        .cfg_q    (cfg_q),
        .flags_q  (flags_q),
        .prev_q   (prev_q)
    );

    assign irq     = |(flags_q & irq_mask);
    assign dma_req = |(flags_q & dma_mask);

    always_comb begin
        rdata = '0;
        if (addr == STAT_ADDR) begin
            rdata[NUM_PINS-1:0] = flags_q;
        end else begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (addr == ADDR_W'(i)) begin
                    rdata[CODE_W-1:0] = cfg_q[i*CODE_W +: CODE_W];
                    rdata[FLAG_BIT]   = flags_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/pin_evt_detector_chk.sv
module pin_evt_detector_chk #(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq,
    input logic                dma_req,
    input logic                dma_done,
    input logic                wr_en,
    input logic [NUM_PINS-1:0] set_vec,
    input logic [NUM_PINS-1:0] clr_vec,
    input logic [NUM_PINS-1:0] flags_q,
    input logic [NUM_PINS-1:0] irq_mask,
    input logic [NUM_PINS-1:0] dma_mask
);

    // R1: outputs quiet on the first edge out of reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && !dma_req));

    // R8: completion pulse with no new DMA detection drops the DMA request
    p_dma_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && !wr_en && ((set_vec & dma_mask) == '0)) |=> !dma_req);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        // R2: a flag only rises after its condition was detected
        p_rise_needs_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_q[i]) |-> $past(set_vec[i]));

        // R10: detection beats a simultaneous clear
        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flags_q[i]);

        // R7: interrupt-mode flag holds without a write-one clear
        p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_q[i] && irq_mask[i] && !clr_vec[i]) |=> flags_q[i]);
    end

endmodule

bind pin_evt_detector pin_evt_detector_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .dma_req  (dma_req),
    .dma_done (dma_done),
    .wr_en    (wr_en),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .flags_q  (flags_q),
    .irq_mask (irq_mask),
    .dma_mask (dma_mask)
);

// File: tb/pin_evt_detector_test.sv
`timescale 1ns/1ps
module pin_evt_detector_test;

    localparam int NP   = 8;
    localparam int DW   = 32;
    localparam int AW   = $clog2(NP + 1);
    localparam int STAT = NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          dma_done = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, dma_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        int          kind;   // 0 status/register word, 1 irq, 2 dma_req
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    pin_evt_detector #(.NUM_PINS(NP), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dma_done(dma_done),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .dma_req(dma_req)
    );

    // monitor: pop expected items and compare with what the design shows
    initial begin
        forever begin
            wait (sb.size() != 0);
            begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                act = (it.kind == 0) ? rdata : (it.kind == 1) ? {31'd0, irq} : {31'd0, dma_req};
                n_checks++;
                if (act !== it.exp) begin
                    n_fails++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(string tag, int kind, logic [31:0] exp);
        #0.5;
        sb.push_back('{tag, kind, exp});
        #0.5;
    endtask

    task automatic chk_stat(string tag, logic [31:0] exp);
        addr = AW'(STAT);
        push(tag, 0, exp);
    endtask

    task automatic chk_reg(string tag, int a, logic [31:0] exp);
        addr = AW'(a);
        push(tag, 0, exp);
    endtask

    task automatic chk_irq(string tag, logic e);
        push(tag, 1, {31'd0, e});
    endtask

    task automatic chk_dma(string tag, logic e);
        push(tag, 2, {31'd0, e});
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic set_pin(int p, logic v);
        @(negedge clk);
        pin_in[p] = v;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_stat("R1 status", 32'h0);
        chk_reg("R1 pin3 reg", 3, 32'h0);
        chk_irq("R1 irq", 1'b0);
        chk_dma("R1 dma", 1'b0);

        // R2 disabled and reserved codes
        wr(2, 32'h5);
        wr(3, 32'hE);
        wr(1, 32'h0);
        for (int k = 0; k < 3; k++) begin
            set_pin(1, 1'b1); set_pin(2, 1'b1); set_pin(3, 1'b1);
            set_pin(1, 1'b0); set_pin(2, 1'b0); set_pin(3, 1'b0);
        end
        chk_stat("R2 status after toggles", 32'h0);
        chk_irq("R2 irq", 1'b0);
        chk_dma("R2 dma", 1'b0);
        chk_reg("R2/R12 pin3 code readback", 3, 32'hE);

        // R3 rising edge, interrupt code 0x9 on pin4
        wr(4, 32'h9);
        set_pin(4, 1'b1);
        chk_stat("R3 rise sets", 32'h10);
        chk_irq("R3/R9 irq", 1'b1);
        chk_dma("R9 no dma", 1'b0);
        chk_reg("R12 pin4 reg flag", 4, 32'h0100_0009);
        wr(4, 32'h0100_0009);
        chk_stat("R12 pin-register clear", 32'h0);
        set_pin(4, 1'b0);
        chk_stat("R3 fall ignored", 32'h0);

        // R4 falling edge, code 0xA on pin5
        wr(5, 32'hA);
        set_pin(5, 1'b1);
        chk_stat("R4 rise ignored", 32'h0);
        set_pin(5, 1'b0);
        chk_stat("R4 fall sets", 32'h20);
        wr(STAT, 32'h20);
        chk_stat("R11 status clear", 32'h0);

        // R5 either edge, code 0xB on pin6
        wr(6, 32'hB);
        set_pin(6, 1'b1);
        chk_stat("R5 rise sets", 32'h40);
        wr(STAT, 32'h40);
        set_pin(6, 1'b0);
        chk_stat("R5 fall sets", 32'h40);
        wr(STAT, 32'h40);
        chk_stat("R5 cleared", 32'h0);

        // R6 level codes on pin7
        wr(7, 32'hC);
        chk_stat("R6 high-level idle while low", 32'h0);
        set_pin(7, 1'b1);
        chk_stat("R6 high-level sets", 32'h80);
        wr(STAT, 32'h80);
        chk_stat("R6 re-sets while high", 32'h80);
        set_pin(7, 1'b0);
        wr(STAT, 32'h80);
        chk_stat("R6 clears once low", 32'h0);
        wr(7, 32'h8);
        idle(1);
        chk_stat("R6 low-level sets", 32'h80);
        set_pin(7, 1'b1);
        wr(STAT, 32'h80);
        chk_stat("R6 low-level clears once high", 32'h0);
        wr(7, 32'h0);

        // R7 interrupt flag held
        set_pin(4, 1'b1);
        set_pin(4, 1'b0);
        idle(5);
        chk_stat("R7 held over time", 32'h10);
        wr(STAT, 32'h0);
        chk_stat("R11 write zero leaves flag", 32'h10);
        wr(4, 32'h9);
        chk_stat("R12 write without bit24 keeps flag", 32'h10);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        chk_stat("R7 dma_done leaves irq flag", 32'h10);
        wr(STAT, 32'h10);
        chk_irq("R9 irq low after clear", 1'b0);

        // R8 DMA completion, pin0 DMA rise, pin1 interrupt rise
        wr(0, 32'h1);
        wr(1, 32'h9);
        @(negedge clk); pin_in[0] = 1'b1; pin_in[1] = 1'b1;
        @(negedge clk);
        chk_stat("R8 both flags", 32'h03);
        chk_irq("R9 irq", 1'b1);
        chk_dma("R9 dma", 1'b1);
        idle(3);
        chk_stat("R8 dma flag holds without done", 32'h03);
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
        chk_stat("R8 done clears only dma pin", 32'h02);
        chk_dma("R8 dma low", 1'b0);
        chk_irq("R8 irq stays", 1'b1);
        wr(STAT, 32'hFFFF_FFFF);
        chk_stat("R11 all-ones clears", 32'h0);
        chk_irq("R11 irq low", 1'b0);

        // R10 set beats clear in the same cycle (pin6 either edge)
        @(negedge clk);
        pin_in[6] = 1'b1;
        wr_en = 1'b1; addr = AW'(STAT); wdata = 32'h40;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        chk_stat("R10 set wins", 32'h40);
        wr(STAT, 32'h40);
        chk_stat("R10 later clear", 32'h0);

        idle(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule